// File: doc/BRIEF.md
# Safe Overclock Clock Selector

This block chooses, once per reconfiguration operation, whether the configuration port runs from the nominal clock (100 MHz) or the boosted clock (133 MHz). Both clocks come from one common reference. The block keeps the most recent temperature, core supply and auxiliary supply readings delivered by an on-chip sensor interface. It compares each reading against its own programmable lower and upper limit. It drives the select line of an external glitch-free clock multiplexer.

The reconfiguration engine pulses a start request before it begins a transfer. On that edge the block latches its decision and raises busy. The select line is then frozen until the engine pulses done, and afterwards it returns to the nominal clock.

The boosted clock is granted only under all of these conditions:
- the sample is fresh, meaning it arrived after the previous decision;
- the sensor flagged the sample as good;
- every reading lies inside its window;
- software has not forced the nominal clock.

Status outputs keep the outcome of the last decision and report one out-of-range flag per monitored quantity.

Top module: `safe_boost_sel`

## Requirements
- R1: After reset, clk_sel, busy, stat_boost and stat_oor are all 0.
- R2: A start request while busy is 0 sets busy to 1 on the next clock edge. On that same edge clk_sel takes the decision value (1 = boosted, 0 = nominal) and stat_boost takes the same value.
- R3: The decision is 1 only when three conditions all hold: the held sample is fresh, it was flagged good, and each reading satisfies lower <= reading <= upper. Both limits are inclusive, so a reading equal to either limit is in range.
- R4: A reading outside its window gives decision 0. stat_oor records one out-of-range flag per channel from the decision edge: bit0 for temperature, bit1 for core supply, bit2 for auxiliary supply.
- R5: A sample strobe with smp_good low makes the held sample not fresh, so the next decision is 0.
- R6: Each decision consumes the held sample. A second operation with no new strobe in between gets decision 0.
- R7: When the force-nominal control bit is 1, every decision is 0, whatever the readings.
- R8: While busy is 1, clk_sel does not change. Further start requests, new samples and limit writes have no effect on clk_sel.
- R9: A done pulse while busy is 1 clears busy, and on the same edge sets clk_sel to 0. stat_boost and stat_oor keep the values from the last decision.
- R10: Configuration writes (cfg_we high) use these addresses:

  | Address | Register |
  |---|---|
  | 0 | temperature lower limit |
  | 1 | temperature upper limit |
  | 2 | core supply lower limit |
  | 3 | core supply upper limit |
  | 4 | auxiliary supply lower limit |
  | 5 | auxiliary supply upper limit |
  | 6 | force-nominal control, bit0 of cfg_wdata |

  At reset all lower limits are 0, all upper limits are all ones, and force-nominal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 10 | Configuration write data |
| smp_strobe | input | 1 | A new sensor sample is present this cycle |
| smp_good | input | 1 | Sensor flags the sample as valid |
| smp_temp | input | 10 | Temperature reading, unsigned |
| smp_vcore | input | 10 | Core supply reading, unsigned |
| smp_vaux | input | 10 | Auxiliary supply reading, unsigned |
| op_start | input | 1 | Reconfiguration engine start request |
| op_done | input | 1 | Reconfiguration engine completion pulse |
| clk_sel | output | 1 | Clock multiplexer select, 1 = boosted |
| busy | output | 1 | Operation in progress, select frozen |
| stat_boost | output | 1 | Outcome of the last decision |
| stat_oor | output | 3 | Out-of-range flags from the last decision |

## Verification
A stuck or wrongly cleared freshness flag shows as a wrong clk_sel on the very next start edge. The stale-sample and bad-flag cases therefore compare clk_sel in the cycle right after the request. A mis-decoded limit register or an off-by-one in the inclusive compare shows in the same cycle, both in stat_oor and in clk_sel. The tests place readings exactly on the limits and one step beyond them. A hold state that leaks would move clk_sel while busy is 1. The bench samples clk_sel on every cycle of the operation while it disturbs the block with fresh samples, limit writes and repeated starts.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int NCH  = 3;
  localparam int DW   = 10;
  localparam int AW   = 3;
  typedef enum logic {ST_IDLE = 1'b0, ST_HOLD = 1'b1} hold_st_e;
endpackage

// File: rtl/sbs_limit_regs.sv
module sbs_limit_regs #(
  parameter int NCH = 3,
  parameter int DW  = 10,
  parameter int AW  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [AW-1:0]           cfg_addr,
  input  logic [DW-1:0]           cfg_wdata,
  output logic [NCH-1:0][DW-1:0]  lim_lo,
  output logic [NCH-1:0][DW-1:0]  lim_hi,
  output logic                    force_nom
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(2 * NCH);

  logic [NCH-1:0][DW-1:0] lo_q, lo_d, hi_q, hi_d;
  logic                   frc_q, frc_d;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    frc_d = frc_q;
    if (cfg_we) begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (cfg_addr == AW'(2 * ch))     lo_d[ch] = cfg_wdata;
        if (cfg_addr == AW'(2 * ch + 1)) hi_d[ch] = cfg_wdata;
      end
      if (cfg_addr == CTRL_ADDR) frc_d = cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '1;
      frc_q <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      frc_q <= frc_d;
    end
  end

  assign lim_lo    = lo_q;
  assign lim_hi    = hi_q;
  assign force_nom = frc_q;
endmodule

// File: rtl/sbs_window.sv
module sbs_window #(
  parameter int DW = 10
) (
  input  logic [DW-1:0] value,
  input  logic [DW-1:0] lower,
  input  logic [DW-1:0] upper,
  output logic          outside
);
  always_comb outside = (value < lower) || (value > upper);
endmodule

// File: rtl/sbs_hold_ctrl.sv
module sbs_hold_ctrl
  import sbs_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_strobe,
  input  logic                    smp_good,
  input  logic [NCH-1:0][DW-1:0]  smp_vals,
  input  logic [NCH-1:0]          chan_oor,
  input  logic                    force_nom,
  input  logic                    op_start,
  input  logic                    op_done,
  output logic [NCH-1:0][DW-1:0]  held_vals,
  output logic                    clk_sel,
  output logic                    busy,
  output logic                    stat_boost,
  output logic [NCH-1:0]          stat_oor
);
  hold_st_e               st_q, st_d;
  logic [NCH-1:0][DW-1:0] held_q, held_d;
  logic                   fresh_q, fresh_d;
  logic                   sel_q, sel_d;
  logic                   sb_q, sb_d;
  logic [NCH-1:0]         oor_q, oor_d;
  logic                   decide, boost_ok;

  always_comb begin
    decide   = (st_q == ST_IDLE) && op_start;
    boost_ok = fresh_q && !force_nom && !(|chan_oor);

    held_d  = smp_strobe ? smp_vals : held_q;
    fresh_d = fresh_q;
    if (decide)     fresh_d = 1'b0;
    if (smp_strobe) fresh_d = smp_good;

    st_d  = st_q;
    sel_d = sel_q;
    sb_d  = sb_q;
    oor_d = oor_q;
    unique case (st_q)
      ST_IDLE: if (op_start) begin
        st_d  = ST_HOLD;
        sel_d = boost_ok;
        sb_d  = boost_ok;
        oor_d = chan_oor;
      end
      ST_HOLD: if (op_done) begin
        st_d  = ST_IDLE;
        sel_d = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      held_q  <= '0;
      fresh_q <= 1'b0;
      sel_q   <= 1'b0;
      sb_q    <= 1'b0;
      oor_q   <= '0;
    end else begin
      st_q    <= st_d;
      held_q  <= held_d;
      fresh_q <= fresh_d;
      sel_q   <= sel_d;
      sb_q    <= sb_d;
      oor_q   <= oor_d;
    end
  end

  assign held_vals  = held_q;
  assign clk_sel    = sel_q;
  assign busy       = (st_q == ST_HOLD);
  assign stat_boost = sb_q;
  assign stat_oor   = oor_q;
endmodule

// File: rtl/safe_boost_sel.sv
module safe_boost_sel #(
  parameter int DW = sbs_pkg::DW,
  parameter int AW = sbs_pkg::AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          smp_strobe,
  input  logic          smp_good,
  input  logic [DW-1:0] smp_temp,
  input  logic [DW-1:0] smp_vcore,
  input  logic [DW-1:0] smp_vaux,
  input  logic          op_start,
  input  logic          op_done,
  output logic          clk_sel,
  output logic          busy,
  output logic          stat_boost,
  output logic [2:0]    stat_oor
);
  localparam int NCH = sbs_pkg::NCH;

  logic [NCH-1:0][DW-1:0] lim_lo, lim_hi, smp_vals, held_vals;
  logic [NCH-1:0]         chan_oor;
  logic                   force_nom;

  assign smp_vals = {smp_vaux, smp_vcore, smp_temp};

  sbs_limit_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .force_nom(force_nom)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_win
    sbs_window #(.DW(DW)) u_win (
      .value(held_vals[g]), .lower(lim_lo[g]), .upper(lim_hi[g]),
      .outside(chan_oor[g])
    );
  end

  sbs_hold_ctrl #(.NCH(NCH), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .smp_good(smp_good),
    .smp_vals(smp_vals), .chan_oor(chan_oor), .force_nom(force_nom),
    .op_start(op_start), .op_done(op_done), .held_vals(held_vals),
    .clk_sel(clk_sel), .busy(busy), .stat_boost(stat_boost),
    .stat_oor(stat_oor)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       op_start,
  input logic       op_done,
  input logic       busy,
  input logic       clk_sel,
  input logic       stat_boost,
  input logic [2:0] stat_oor,
  input logic       force_nom
);
  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && op_start) |=> busy);

  // R8
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(clk_sel));

  // R9
  done_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done) |=> (!busy && !clk_sel));

  // R3
  boost_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> (busy && stat_boost));

  // R4
  boost_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_boost |-> (stat_oor == 3'b000));

  // R7
  force_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy) && $past(force_nom)) |-> !clk_sel);
endmodule

bind safe_boost_sel sbs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done),
  .busy(busy), .clk_sel(clk_sel), .stat_boost(stat_boost),
  .stat_oor(stat_oor), .force_nom(force_nom)
);

// File: tb/safe_boost_sel_tb.sv
module safe_boost_sel_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [9:0] cfg_wdata;
  logic       smp_strobe, smp_good;
  logic [9:0] smp_temp, smp_vcore, smp_vaux;
  logic       op_start, op_done;
  logic       clk_sel, busy, stat_boost;
  logic [2:0] stat_oor;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  safe_boost_sel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp_strobe(smp_strobe), .smp_good(smp_good),
    .smp_temp(smp_temp), .smp_vcore(smp_vcore), .smp_vaux(smp_vaux),
    .op_start(op_start), .op_done(op_done), .clk_sel(clk_sel),
    .busy(busy), .stat_boost(stat_boost), .stat_oor(stat_oor)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [9:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_sample(input logic good, input int t, input int vc, input int va);
    @(negedge clk);
    smp_strobe = 1'b1; smp_good = good;
    smp_temp = 10'(t); smp_vcore = 10'(vc); smp_vaux = 10'(va);
    @(negedge clk);
    smp_strobe = 1'b0;
  endtask

  task automatic run_op(input logic exp_sel, input logic [2:0] exp_oor, input string req);
    @(negedge clk);
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    chk(busy, 1, req, "busy after start");
    chk(clk_sel, exp_sel, req, "clk_sel after start");
    chk(stat_boost, exp_sel, req, "stat_boost after start");
    chk(stat_oor, exp_oor, req, "stat_oor after start");
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    chk(busy, 0, "R9", "busy after done");
    chk(clk_sel, 0, "R9", "clk_sel after done");
  endtask

  task automatic t_reset;
    chk(clk_sel, 0, "R1", "clk_sel reset");
    chk(busy, 0, "R1", "busy reset");
    chk(stat_boost, 0, "R1", "stat_boost reset");
    chk(stat_oor, 0, "R1", "stat_oor reset");
  endtask

  task automatic t_defaults;
    // R10: default windows pass everything
    send_sample(1'b1, 0, 1023, 512);
    run_op(1'b1, 3'b000, "R10");
  endtask

  task automatic program_limits;
    cfg_write(3'd0, 10'd100); cfg_write(3'd1, 10'd500);
    cfg_write(3'd2, 10'd200); cfg_write(3'd3, 10'd800);
    cfg_write(3'd4, 10'd300); cfg_write(3'd5, 10'd900);
  endtask

  task automatic t_in_range;
    send_sample(1'b1, 250, 500, 600);
    run_op(1'b1, 3'b000, "R2");
  endtask

  task automatic t_hold;
    send_sample(1'b1, 250, 500, 600);
    @(negedge clk);
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    chk(clk_sel, 1, "R8", "select at start");
    send_sample(1'b1, 5, 5, 5);
    chk(clk_sel, 1, "R8", "after sample while busy");
    cfg_write(3'd6, 10'd1);
    chk(clk_sel, 1, "R8", "after force while busy");
    cfg_write(3'd0, 10'd0);
    chk(clk_sel, 1, "R8", "after limit write while busy");
    @(negedge clk);
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    chk(clk_sel, 1, "R8", "after repeated start");
    chk(busy, 1, "R8", "busy after repeated start");
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    chk(busy, 0, "R9", "busy released");
    chk(clk_sel, 0, "R9", "clk_sel nominal after done");
    chk(stat_boost, 1, "R9", "stat_boost kept");
    chk(stat_oor, 0, "R9", "stat_oor kept");
    cfg_write(3'd6, 10'd0);
    cfg_write(3'd0, 10'd100);
  endtask

  task automatic t_bounds;
    send_sample(1'b1, 100, 800, 300);
    run_op(1'b1, 3'b000, "R3");
    send_sample(1'b1, 500, 200, 900);
    run_op(1'b1, 3'b000, "R3");
    send_sample(1'b1, 99, 500, 600);
    run_op(1'b0, 3'b001, "R4");
    send_sample(1'b1, 250, 801, 600);
    run_op(1'b0, 3'b010, "R4");
    send_sample(1'b1, 250, 500, 901);
    run_op(1'b0, 3'b100, "R4");
    send_sample(1'b1, 501, 199, 299);
    run_op(1'b0, 3'b111, "R4");
  endtask

  task automatic t_bad_flag;
    send_sample(1'b0, 250, 500, 600);
    run_op(1'b0, 3'b000, "R5");
  endtask

  task automatic t_stale;
    send_sample(1'b1, 250, 500, 600);
    run_op(1'b1, 3'b000, "R6");
    run_op(1'b0, 3'b000, "R6");
  endtask

  task automatic t_force;
    cfg_write(3'd6, 10'd1);
    send_sample(1'b1, 250, 500, 600);
    run_op(1'b0, 3'b000, "R7");
    cfg_write(3'd6, 10'd0);
    send_sample(1'b1, 250, 500, 600);
    run_op(1'b1, 3'b000, "R7");
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    smp_strobe = 1'b0; smp_good = 1'b0;
    smp_temp = '0; smp_vcore = '0; smp_vaux = '0;
    op_start = 1'b0; op_done = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defaults();
    program_limits();
    t_in_range();
    t_hold();
    t_bounds();
    t_bad_flag();
    t_stale();
    t_force();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule